// File: doc/BRIEF.md
# Hold-Mode and Reset Sequencer

This block decides when the processor core of a small controller may run. Software requests a deep, clock-stopped hold state by executing a hold instruction. The request succeeds only if the external hold-control pin is already low. While the block is in hold, the core clock is gated off. When the pin goes high again the block starts a restart. The restart does not hand the clock back at once. It first counts a fixed number of oscillator cycles so the oscillator can settle. Then it releases the core and gives peripherals a one-cycle preset strobe, so they can load their values for after hold.

The block also qualifies the active-low external reset pin. A low level on that pin is accepted only while the hold-control pin is high, and only after it has stayed low for a minimum number of consecutive cycles. While reset is applied, the core is held in reset with its clock running. When the reset pin is released, the same settling count runs before the core starts. A reset accepted during the settling count restarts that count. Both pins are synchronised before use. The settling counter runs on the free-running oscillator clock, so it keeps counting while the core clock is gated.

Top module: `hold_reset_seq`

## Requirements
- R1: A hold request (`hold_op` high for one cycle) while the core is running and the synchronised hold pin is low moves the block into hold at that clock edge. From then on `cpu_run`=0, `clk_en`=0 and `hold_flag`=1.
- R2: A hold request while the synchronised hold pin is high is ignored: `cpu_run` stays 1 and `hold_flag` stays 0.
- R3: In hold, the block stays put as long as the hold pin is low. A high level on the pin starts the settling count. Throughout the count `hold_flag`=1, `clk_en`=0 and `cpu_run`=0.
- R4: The settling count lasts exactly WAKE_CYCLES clock cycles (default 16384). Measured from the first edge after the hold pin rises, `cpu_run` becomes 1 after SYNC_STAGES+1+WAKE_CYCLES edges.
- R5: `preset` is high for exactly one cycle, in the first cycle of `cpu_run`=1 after every settling count, and is low at all other times.
- R6: A low level on `res_n` is accepted as a reset only after RES_MIN (default 3) consecutive synchronised low cycles while the hold pin is high. A shorter low pulse never raises `sys_rst`.
- R7: While the synchronised hold pin is low, `res_n` has no effect: `sys_rst` stays 0 and the hold state is kept.
- R8: While a reset is applied, `sys_rst`=1, `clk_en`=1 and `cpu_run`=0. When `res_n` returns high, a full settling count follows, so `cpu_run` rises after SYNC_STAGES+1+WAKE_CYCLES edges.
- R9: A reset accepted during the settling count abandons that count. A full new count starts after `res_n` is released.
- R10: The synchronous power-on input `rst` puts the block in the reset state (`sys_rst`=1, `clk_en`=1, `cpu_run`=0, `hold_flag`=0, `preset`=0). After `rst` falls with `res_n` high, `cpu_run` rises after WAKE_CYCLES+1 edges.
- R11: `hold_pin` and `res_n` pass through SYNC_STAGES flip-flops before they affect any decision, and every output is a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hold_pin | input | 1 | Hold-control pin: low allows hold and blocks reset, high wakes |
| res_n | input | 1 | External reset pin, active low |
| hold_op | input | 1 | One-cycle strobe: hold instruction executed |
| cpu_run | output | 1 | Core run enable, high only in normal running |
| clk_en | output | 1 | Core clock gate enable |
| sys_rst | output | 1 | Core and peripheral reset level |
| preset | output | 1 | One-cycle preset strobe when the core resumes |
| hold_flag | output | 1 | High in hold and during the settling count |

## Verification
A wrong state would show at the ports at the next clock edge. A missed hold entry leaves `cpu_run` high. A reset taken while the hold pin is low raises `sys_rst`. A settling count that is miscounted or not restarted moves the rising edge of `cpu_run` and `preset` by whole cycles. The bench therefore measures the exact cycle at which the core resumes, for several hold lengths and after each kind of reset. It sweeps reset pulse lengths around the acceptance threshold and confirms that `preset` lasts a single cycle.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [1:0] {
    HRS_RUN   = 2'd0,
    HRS_HOLD  = 2'd1,
    HRS_WAKE  = 2'd2,
    HRS_RESET = 2'd3
  } hrs_state_e;
endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hrs_res_filter.sv
module hrs_res_filter #(
  parameter int RES_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic res_low,
  input  logic allow,
  output logic take
);
  localparam int CW  = (RES_MIN > 1) ? $clog2(RES_MIN) : 1;
  localparam logic [CW-1:0] LIM = CW'(RES_MIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (res_low && allow) begin
      if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign take = res_low && allow && (cnt_q == LIM);
endmodule

// File: rtl/hrs_settle_timer.sv
module hrs_settle_timer #(
  parameter int WAKE_CYCLES = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] START = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= START;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/hold_reset_seq.sv
module hold_reset_seq
  import hrs_pkg::*;
#(
  parameter int WAKE_CYCLES = 16384,
  parameter int SYNC_STAGES = 2,
  parameter int RES_MIN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_pin,
  input  logic res_n,
  input  logic hold_op,
  output logic cpu_run,
  output logic clk_en,
  output logic sys_rst,
  output logic preset,
  output logic hold_flag
);
  logic [1:0] pins_s;
  logic       hold_q;
  logic       res_low;
  logic       res_take;
  logic       t_load;
  logic       t_run;
  logic       t_done;
  hrs_state_e st_q;
  hrs_state_e st_d;

  hrs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({hold_pin, res_n}),
    .dout (pins_s)
  );

  assign hold_q  = pins_s[1];
  assign res_low = ~pins_s[0];

  hrs_res_filter #(.RES_MIN(RES_MIN)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .res_low (res_low),
    .allow   (hold_q),
    .take    (res_take)
  );

  hrs_settle_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .run  (t_run),
    .done (t_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HRS_RUN: begin
        if (res_take)               st_d = HRS_RESET;
        else if (hold_op && !hold_q) st_d = HRS_HOLD;
      end
      HRS_HOLD: begin
        if (hold_q) st_d = HRS_WAKE;
      end
      HRS_WAKE: begin
        if (res_take)    st_d = HRS_RESET;
        else if (t_done) st_d = HRS_RUN;
      end
      HRS_RESET: begin
        if (!res_low) st_d = HRS_WAKE;
      end
      default: st_d = HRS_RESET;
    endcase
  end

  assign t_load = (st_d == HRS_WAKE) && (st_q != HRS_WAKE);
  assign t_run  = (st_q == HRS_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= HRS_RESET;
      cpu_run   <= 1'b0;
      clk_en    <= 1'b1;
      sys_rst   <= 1'b1;
      preset    <= 1'b0;
      hold_flag <= 1'b0;
    end else begin
      st_q      <= st_d;
      cpu_run   <= (st_d == HRS_RUN);
      clk_en    <= (st_d == HRS_RUN) || (st_d == HRS_RESET);
      sys_rst   <= (st_d == HRS_RESET);
      preset    <= (st_q == HRS_WAKE) && (st_d == HRS_RUN);
      hold_flag <= (st_d == HRS_HOLD) || (st_d == HRS_WAKE);
    end
  end
endmodule

// File: rtl/hold_reset_seq_chk.sv
module hold_reset_seq_chk
  import hrs_pkg::*;
#(
  parameter int WAKE_CYCLES = 16384
) (
  input logic       clk,
  input logic       rst,
  input logic       hold_op,
  input logic       hold_s,
  input hrs_state_e st,
  input logic       cpu_run,
  input logic       clk_en,
  input logic       sys_rst,
  input logic       preset,
  input logic       hold_flag
);
  int wake_len;

  always_ff @(posedge clk) begin
    if (rst) wake_len <= 0;
    else     wake_len <= (st == HRS_WAKE) ? wake_len + 1 : 0;
  end

  p_enter_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_run && hold_op && !hold_s) |=> (hold_flag && !clk_en && !cpu_run));

  p_stay_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st == HRS_HOLD && !hold_s) |=> (hold_flag && !cpu_run && !clk_en));

  p_wait_len_r4: assert property (@(posedge clk) disable iff (rst)
    preset |-> (wake_len == WAKE_CYCLES));

  p_preset_single_r5: assert property (@(posedge clk) disable iff (rst)
    preset |=> !preset);

  p_res_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (!hold_s && !sys_rst) |=> !sys_rst);

  p_run_excl_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_run |-> (clk_en && !sys_rst && !hold_flag));
endmodule

bind hold_reset_seq hold_reset_seq_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold_op   (hold_op),
  .hold_s    (hold_q),
  .st        (st_q),
  .cpu_run   (cpu_run),
  .clk_en    (clk_en),
  .sys_rst   (sys_rst),
  .preset    (preset),
  .hold_flag (hold_flag)
);

// File: tb/hold_reset_seq_test.sv
module hold_reset_seq_test;
  localparam int W    = 20;
  localparam int SYNC = 2;
  localparam int RMIN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_pin = 1'b1;
  logic res_n = 1'b1;
  logic hold_op = 1'b0;
  logic cpu_run, clk_en, sys_rst, preset, hold_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  hold_reset_seq #(.WAKE_CYCLES(W), .SYNC_STAGES(SYNC), .RES_MIN(RMIN)) uut (
    .clk(clk), .rst(rst), .hold_pin(hold_pin), .res_n(res_n), .hold_op(hold_op),
    .cpu_run(cpu_run), .clk_en(clk_en), .sys_rst(sys_rst), .preset(preset),
    .hold_flag(hold_flag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges after the current one until cpu_run is high
  task automatic count_run(output int n, output int flag_ok);
    n = 0;
    flag_ok = 1;
    while (n < 4 * W + 50) begin
      @(negedge clk);
      n++;
      if (cpu_run) break;
      if (!sys_rst && clk_en) flag_ok = 0;
    end
  endtask

  task automatic check_preset(input string req);
    chk(req, int'(preset), 1);
    step(1);
    chk(req, int'(preset), 0);
  endtask

  task automatic pulse_hold_op;
    hold_op = 1'b1;
    step(1);
    hold_op = 1'b0;
  endtask

  initial begin
    int n;
    int fok;
    int seen;
    step(3);
    // R10 reset state
    chk("R10 cpu_run", int'(cpu_run), 0);
    chk("R10 sys_rst", int'(sys_rst), 1);
    chk("R10 clk_en", int'(clk_en), 1);
    chk("R10 hold_flag", int'(hold_flag), 0);
    chk("R10 preset", int'(preset), 0);
    rst = 1'b0;
    count_run(n, fok);
    chk("R10 start latency", n, W + 1);
    check_preset("R5 after power-on");
    step(3);

    // R2 hold request ignored with hold pin high
    pulse_hold_op();
    step(2);
    chk("R2 cpu_run", int'(cpu_run), 1);
    chk("R2 hold_flag", int'(hold_flag), 0);

    // R1/R3/R4/R7 sweep over hold durations
    for (int d = 1; d <= 6; d++) begin
      hold_pin = 1'b0;
      step(SYNC + 1);
      pulse_hold_op();
      chk("R1 cpu_run", int'(cpu_run), 0);
      chk("R1 clk_en", int'(clk_en), 0);
      chk("R1 hold_flag", int'(hold_flag), 1);
      if (d == 3) begin
        res_n = 1'b0;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
          step(1);
          if (sys_rst) seen = 1;
        end
        res_n = 1'b1;
        step(SYNC + 1);
        chk("R7 no reset while held", seen, 0);
      end
      step(3 * d);
      chk("R3 still in hold", int'(hold_flag && !cpu_run && !clk_en), 1);
      hold_pin = 1'b1;
      count_run(n, fok);
      chk("R4 wake latency", n, SYNC + 1 + W);
      chk("R3 gated during count", fok, 1);
      check_preset("R5 after hold");
      step(2);
    end

    // R6 sweep over reset pulse lengths
    for (int len = 1; len <= 5; len++) begin
      res_n = 1'b0;
      seen = 0;
      for (int k = 0; k < len; k++) begin
        step(1);
        if (sys_rst) seen = 1;
      end
      res_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
        step(1);
        if (sys_rst) seen = 1;
      end
      chk("R6 reset acceptance", seen, (len >= RMIN) ? 1 : 0);
      if (!cpu_run) begin
        count_run(n, fok);
        chk("R6 resumes", int'(cpu_run), 1);
      end
      step(3);
    end

    // R8 long reset, exact restart latency
    res_n = 1'b0;
    step(10);
    chk("R8 sys_rst", int'(sys_rst), 1);
    chk("R8 clk_en", int'(clk_en), 1);
    chk("R8 cpu_run", int'(cpu_run), 0);
    res_n = 1'b1;
    count_run(n, fok);
    chk("R8 restart latency", n, SYNC + 1 + W);
    check_preset("R5 after reset");
    step(2);

    // R9 reset during settling count restarts it
    hold_pin = 1'b0;
    step(SYNC + 1);
    pulse_hold_op();
    step(2);
    hold_pin = 1'b1;
    step(SYNC + 1 + W / 2);
    chk("R9 in count", int'(hold_flag), 1);
    res_n = 1'b0;
    step(SYNC + RMIN + 2);
    chk("R9 reset taken", int'(sys_rst), 1);
    chk("R9 flag cleared", int'(hold_flag), 0);
    res_n = 1'b1;
    count_run(n, fok);
    chk("R9 full recount", n, SYNC + 1 + W);
    check_preset("R5 after R9");

    // R11 hold pin change takes effect only after synchroniser
    hold_pin = 1'b0;
    step(1);
    pulse_hold_op();
    chk("R11 sync delay", int'(cpu_run), 1);
    hold_pin = 1'b1;
    step(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule